// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

The block is a small 32-bit processor. In every clock cycle it fetches one instruction, decodes it, executes it and retires it. It handles five register-to-register operations (add, subtract, signed set-less-than, AND, OR), word load, word store, branch-if-equal and an absolute jump. The instruction memory and the data memory are separate. Two dedicated adders serve the sequential address and the branch target. All instruction decode and operand selection is combinational, so the clock period must cover the longest path: fetch, register read, ALU, data memory and write-back.

Both memories are small internal word arrays with no reset. A preload port fills them while reset is held. The core's own activity can be watched at three places: the program counter output, the register write-back bus and the data-memory store bus. An asynchronous active-low reset is released to the core through a two-stage synchroniser, so execution of word 0 begins on the second rising edge after reset is released.

Top module: `sc_core`

## Requirements
- R1: While reset is active, and until the core leaves reset, the PC output is 0 and neither write bus asserts. All 31 writable registers start at zero.
- R2: For opcode 0x00, funct 0x20 adds, 0x22 subtracts, 0x24 ANDs, 0x25 ORs and 0x2A gives 1 if rs is less than rt as signed values (0 otherwise). The result goes to register rd, which is instr[15:11]. rs is instr[25:21] and rt is instr[20:16]. Bits [10:6] are ignored.
- R3: Register 0 always reads as zero. A write aimed at register 0 still shows on the write-back bus but changes nothing.
- R4: Load word (opcode 0x23) forms the address rs + sign-extended instr[15:0]. It writes the data word at index address[7:2] into register rt.
- R5: Store word (opcode 0x2B) presents the same address and the rt value on the store bus. It writes the data word at index address[7:2] and does not write any register.
- R6: Branch-if-equal (opcode 0x04) sets the next PC to PC+4 + (sign-extended instr[15:0] << 2) when rs equals rt, and to PC+4 otherwise.
- R7: Jump (opcode 0x02) sets the next PC to {PC+4 [31:28], instr[25:0], 2'b00}. It writes nothing.
- R8: Every other instruction advances the PC by 4 on every clock edge. Instructions are fetched from word index PC[7:2].
- R9: Any other opcode, and any opcode-0x00 funct not listed in R2, writes neither a register nor the data memory.
- R10: An instruction whose destination is also one of its sources reads the old value. The new value is visible from the next instruction on.
- R11: While reset is held, a preload write with the memory select at 0 fills instruction word ld_addr, and with the select at 1 fills data word ld_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write-back strobe |
| rf_waddr_o | output | 5 | Register write-back address |
| rf_wdata_o | output | 32 | Register write-back data |
| dm_we_o | output | 1 | Data-memory store strobe |
| dm_addr_o | output | 32 | Load/store byte address (ALU result) |
| dm_wdata_o | output | 32 | Store data |

## Verification
Two things happen in the same cycle of one instruction: reading a register through the operand ports, and writing that same register at the closing edge. They collide whenever the destination equals a source. The random programs draw all register fields from registers 0 to 7, so such collisions, and writes to register 0, come up often. A lockstep instruction model in the bench predicts the write-back value from the pre-edge register contents and checks that the next instruction sees the new one. The same model checks that a taken branch and a jump select the next PC correctly against the sequential path.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OPC_RFMT  = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic    dst_rd;
    logic    b_imm;
    logic    wb_mem;
    logic    rf_wr;
    logic    mem_wr;
    logic    is_beq;
    logic    is_jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      words[waddr] <= wdata;
    end
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NR = NREG,
  parameter int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);
  logic [NR-1:0][DW-1:0] bank;

  for (genvar i = 0; i < NR; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign bank[i] = '0;
    end else begin : g_live
      logic [DW-1:0] q;
      logic [DW-1:0] d;
      logic          hit;

      assign hit = we && (waddr == AW'(i));

      always_comb begin
        d = q;
        if (hit) begin
          d = wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else begin
          q <= d;
        end
      end

      assign bank[i] = q;
    end
  end

  assign rd_a = bank[ra_a];
  assign rd_b = bank[ra_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_fn_e       fn,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    unique case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    alu_fn,
  output logic       fn_ok
);
  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = AOP_ADD;
    unique case (opcode)
      OPC_RFMT: begin
        ctrl.dst_rd = 1'b1;
        ctrl.rf_wr  = 1'b1;
        ctrl.alu_op = AOP_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.b_imm  = 1'b1;
        ctrl.wb_mem = 1'b1;
        ctrl.rf_wr  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_beq = 1'b1;
        ctrl.alu_op = AOP_SUB;
      end
      OPC_JUMP: begin
        ctrl.is_jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    alu_fn = ALU_ADD;
    fn_ok  = 1'b1;
    unique case (ctrl.alu_op)
      AOP_ADD: alu_fn = ALU_ADD;
      AOP_SUB: alu_fn = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_ADD:  alu_fn = ALU_ADD;
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: fn_ok  = 1'b0;
        endcase
      end
      default: fn_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IM_AW = 6,
  parameter int DM_AW = 6,
  parameter int LD_AW = (IM_AW > DM_AW) ? IM_AW : DM_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dm_we_o,
  output logic [31:0]      dm_addr_o,
  output logic [31:0]      dm_wdata_o
);
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe[1];

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y;
  logic [XLEN-1:0] dm_rdata, wb_data;
  logic [RAW-1:0]  wr_sel;
  logic            alu_zero, fn_ok, take_br, core_st, rf_wr_eff;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;

  logic            dm_we_mux;
  logic [DM_AW-1:0] dm_waddr_mux;
  logic [XLEN-1:0]  dm_wdata_mux;
  logic            ld_to_im, ld_to_dm;

  assign ld_to_im = ld_en && !ld_dmem;
  assign ld_to_dm = ld_en && ld_dmem;

  sc_mem #(.DW(XLEN), .AW(IM_AW)) u_imem (
    .clk   (clk),
    .we    (ld_to_im),
    .waddr (ld_addr[IM_AW-1:0]),
    .wdata (ld_data),
    .raddr (pc_q[IM_AW+1:2]),
    .rdata (instr)
  );

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .alu_fn (alu_fn),
    .fn_ok  (fn_ok)
  );

  assign wr_sel    = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_wr_eff = ctrl.rf_wr && fn_ok && core_rst_n;

  sc_regfile #(.DW(XLEN), .NR(NREG), .AW(RAW)) u_rf (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (rf_wr_eff),
    .waddr (wr_sel),
    .wdata (wb_data),
    .ra_a  (instr[25:21]),
    .rd_a  (rs_val),
    .ra_b  (instr[20:16]),
    .rd_b  (rt_val)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.DW(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign core_st      = ctrl.mem_wr && core_rst_n;
  assign dm_we_mux    = ld_to_dm || core_st;
  assign dm_waddr_mux = ld_to_dm ? ld_addr[DM_AW-1:0] : alu_y[DM_AW+1:2];
  assign dm_wdata_mux = ld_to_dm ? ld_data : rt_val;

  sc_mem #(.DW(XLEN), .AW(DM_AW)) u_dmem (
    .clk   (clk),
    .we    (dm_we_mux),
    .waddr (dm_waddr_mux),
    .wdata (dm_wdata_mux),
    .raddr (alu_y[DM_AW+1:2]),
    .rdata (dm_rdata)
  );

  assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;

  assign pc_plus4   = pc_q + XLEN'(4);
  assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
  assign take_br    = ctrl.is_beq && alu_zero;

  always_comb begin
    pc_d = pc_plus4;
    if (ctrl.is_jump) begin
      pc_d = jmp_target;
    end else if (take_br) begin
      pc_d = br_target;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_wr_eff;
  assign rf_waddr_o = wr_sel;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = core_st;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        core_rst_n,
  input logic [31:0] pc_o,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        rf_we_o,
  input logic [31:0] rf_wdata_o,
  input logic        dm_we_o
);
  logic [5:0]  opc;
  logic        known_op;
  logic [31:0] pc4, br_exp, jmp_exp;

  assign opc      = instr[31:26];
  assign known_op = (opc == 6'h00) || (opc == 6'h23) || (opc == 6'h2B) ||
                    (opc == 6'h04) || (opc == 6'h02);
  assign pc4      = pc_o + 32'd4;
  assign br_exp   = pc4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_exp  = {pc4[31:28], instr[25:0], 2'b00};

  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (!rf_we_o && !dm_we_o && pc_o == 32'd0));

  a_r3_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

  a_r5_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we_o |-> !rf_we_o);

  a_r6_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && opc == 6'h04 && rs_val == rt_val) |=> (pc_o == $past(br_exp)));

  a_r6_beq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && opc == 6'h04 && rs_val != rt_val) |=> (pc_o == $past(pc4)));

  a_r7_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && opc == 6'h02) |=> (pc_o == $past(jmp_exp)));

  a_r8_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && opc != 6'h02 && opc != 6'h04) |=> (pc_o == $past(pc4)));

  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n && !known_op) |-> (!rf_we_o && !dm_we_o));

  a_r2_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && opc == 6'h00 && instr[5:0] == 6'h2A) |-> (rf_wdata_o < 32'd2));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .pc_o       (pc_o),
  .instr      (instr),
  .rs_val     (rs_val),
  .rt_val     (rt_val),
  .rf_we_o    (rf_we_o),
  .rf_wdata_o (rf_wdata_o),
  .dm_we_o    (dm_we_o)
);

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int NPROG = 14;
  localparam int NRUN  = 220;

  logic          clk;
  logic          rst_n;
  logic          ld_en;
  logic          ld_dmem;
  logic [AW-1:0] ld_addr;
  logic [31:0]   ld_data;
  logic [31:0]   pc_o;
  logic          rf_we_o;
  logic [4:0]    rf_waddr_o;
  logic [31:0]   rf_wdata_o;
  logic          dm_we_o;
  logic [31:0]   dm_addr_o;
  logic [31:0]   dm_wdata_o;

  sc_core dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [31:0] m_im [DEPTH];
  logic [31:0] m_dm [DEPTH];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h pc=%h", tag, act, exp, m_pc);
    end
  endtask

  function automatic logic [31:0] rfmt(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'($urandom_range(0, 31)), fn};
  endfunction

  function automatic logic [31:0] gen_instr();
    int sel = $urandom_range(0, 99);
    int rs  = $urandom_range(0, 7);
    int rt  = $urandom_range(0, 7);
    int rd  = $urandom_range(0, 7);
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    if (sel < 40) return rfmt(rs, rt, rd, fns[$urandom_range(0, 4)]);
    if (sel < 55) return {6'h23, 5'(rs), 5'(rt), 16'($urandom)};
    if (sel < 68) return {6'h2B, 5'(rs), 5'(rt), 16'($urandom)};
    if (sel < 82) return {6'h04, 5'(rs), 5'(($urandom_range(0, 3) == 0) ? rs : rt),
                          16'(int'($urandom_range(0, 15)) - 8)};
    if (sel < 88) return {6'h02, 26'($urandom)};
    if (sel < 93) return {6'h05 + 6'($urandom_range(0, 3)), 26'($urandom)};
    if (sel < 97) return rfmt(rs, rt, rd, 6'h21);
    return 32'h0;
  endfunction

  function automatic logic [31:0] gen_data();
    case ($urandom_range(0, 7))
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  task automatic load_word(input bit to_dm, input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_en   = 1'b1;
    ld_dmem = to_dm;
    ld_addr = AW'(idx);
    ld_data = w;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  task automatic run_program(input int p);
    string tag, ptag;
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      m_im[i] = (p == 0 && i == 0) ? {6'h23, 5'd0, 5'd1, 16'd8} : gen_instr();
      load_word(1'b0, i, m_im[i]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      m_dm[i] = gen_data();
      load_word(1'b1, i, m_dm[i]);
    end
    for (int r = 0; r < 32; r++) m_rf[r] = 32'h0;
    m_pc = 32'h0;
    @(negedge clk);
    chk("R1 pc in reset", pc_o, 32'h0);
    chk("R1 rf_we in reset", {31'b0, rf_we_o}, 32'h0);
    chk("R1 dm_we in reset", {31'b0, dm_we_o}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk("R1 still quiet one edge after release", pc_o, 32'h0);
    ptag = "R1 start pc";
    for (int c = 0; c < NRUN; c++) begin
      logic [31:0] ins, a, b, sx, pc4, nxt, res, addr;
      logic [5:0]  op, fn;
      logic [4:0]  rs, rt, rd, wa;
      bit          ewe, edwe;
      @(negedge clk);
      ins = m_im[m_pc[AW+1:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      a = m_rf[rs]; b = m_rf[rt];
      sx = {{16{ins[15]}}, ins[15:0]};
      pc4 = m_pc + 32'd4; nxt = pc4;
      ewe = 0; edwe = 0; wa = 0; res = 0; addr = a + sx;
      tag = "R9 no write";
      case (op)
        6'h00: begin
          ewe = 1; wa = rd; tag = "R2 rfmt";
          case (fn)
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: begin ewe = 0; tag = "R9 bad funct"; end
          endcase
          if (ewe && rd == 5'd0) tag = "R3 write r0";
          else if (ewe && (rd == rs || rd == rt)) tag = "R10 rmw same reg";
        end
        6'h23: begin ewe = 1; wa = rt; res = m_dm[addr[AW+1:2]]; tag = "R4 R11 load"; end
        6'h2B: begin edwe = 1; tag = "R5 store"; end
        6'h04: begin tag = "R6 beq"; if (a == b) nxt = pc4 + {sx[29:0], 2'b00}; end
        6'h02: begin tag = "R7 jump"; nxt = {pc4[31:28], ins[25:0], 2'b00}; end
        default: tag = "R9 undefined opcode";
      endcase
      chk({ptag, " pc"}, pc_o, m_pc);
      chk({tag, " rf_we"}, {31'b0, rf_we_o}, {31'b0, ewe});
      chk({tag, " dm_we"}, {31'b0, dm_we_o}, {31'b0, edwe});
      if (ewe) begin
        chk({tag, " waddr"}, {27'b0, rf_waddr_o}, {27'b0, wa});
        chk({tag, " wdata"}, rf_wdata_o, res);
      end
      if (edwe) begin
        chk({tag, " addr"}, dm_addr_o, addr);
        chk({tag, " data"}, dm_wdata_o, b);
      end
      if (ewe && wa != 5'd0) m_rf[wa] = res;
      if (edwe) m_dm[addr[AW+1:2]] = b;
      m_pc = nxt;
      ptag = (op == 6'h04 || op == 6'h02) ? tag : "R8 seq";
    end
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(posedge clk);
    for (int p = 0; p < NPROG; p++) run_program(p);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule